// File: doc/BRIEF.md
# Cascaded Two-Stage Pacer Timer

This block produces the strobe that paces conversions in an acquisition front end. It chains two 16-bit down-counters. The first stage counts timebase enables. Each time the first stage reaches its terminal count, the second stage advances by one. The second stage's terminal count becomes the output tick, so one tick arrives every divisor-A × divisor-B timebase enables. The timebase oscillator is selected outside this block, for example 10 MHz or 1 MHz, and reaches it as a clock-enable pulse, `tb_ce`, in the system clock domain.

Software-style programming uses a byte-wide write port. Per stage, a control word first selects the counting mode, and then the divisor is written low byte then high byte. The divisor loads, and the stage starts, only when the high byte is written. For a clean start, the second stage is programmed before the first. The control word also stops the chain: writing a one-shot mode to a stage halts it. A small enable register chooses between free-running and externally gated pacing, and holds the clock-source choice for an auxiliary counter.

Address map: 0 = stage A divisor byte, 1 = stage B divisor byte, 2 = enable register, 3 = control word.

Top module: `pacer_timer`

## Requirements
- R1: After synchronous reset, `tick` and `aux_clk_int` are 0 and no tick appears until both stages are programmed.
- R2: With both stages in rate mode (control bits [3:1] = 3'b010) and `tb_ce` high every cycle, successive ticks are exactly divisorA × divisorB cycles apart.
- R3: A written divisor of 0 counts as 65536. The first tick after loading A=0 with B=2 comes 131072 cycles after the load edge.
- R4: A written divisor of 1 behaves as a divisor of 2.
- R5: `tick` is high for exactly one system clock cycle per period.
- R6: Counting advances only on cycles where `tb_ce` is high. With `tb_ce` high one cycle in N, the tick period is N × divisorA × divisorB cycles.
- R7: When enable register bit 0 is 1, stage A advances only while `ext_gate` is high. When bit 0 is 0, the pacer runs regardless of `ext_gate`.
- R8: `aux_clk_int` follows enable register bit 1, one cycle after the write.
- R9: A control word with mode bits [3:1] other than 3'b010, for example 8'h30 for stage A, stops periodic ticks.
- R10: Writing only the low divisor byte (the first data write after a load) leaves the running period unchanged. The new divisor takes effect on the following high-byte write.
- R11: A control word whose stage field (bits [7:6]) names a stage that does not exist is ignored. Stage A is 0 and stage B is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_ce | input | 1 | Timebase enable, one pulse per oscillator period |
| ext_gate | input | 1 | External gate for stage A when gated mode is on |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| tick | output | 1 | Single-cycle pacing strobe |
| aux_clk_int | output | 1 | Auxiliary counter clock select (1 = internal) |

## Verification
The bench targets several corner cases:
- Divisor values 0 and 1. A design that skipped the remap would stall for 0 or fire every cycle for 1.
- Sparse `tb_ce`. A design that counted raw clocks would tick too early.
- A low-byte-only write. A design that loaded on every byte would change the period partway through a divisor update.
- A control word for a stage that does not exist, and the gated mode with the gate held low. Both must leave the output unchanged.
- The high-byte boundary, with a divisor of 256. A design that swapped the byte order would run at the wrong rate.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  // Mode field of the control word, bits [3:1]
  localparam logic [2:0] MODE_ONESHOT = 3'b000;
  localparam logic [2:0] MODE_RATE    = 3'b010;
  // Width of the stage-select field at the top of the control word
  localparam int SEL_W = 2;
endpackage

// File: rtl/pacer_stage.sv
module pacer_stage #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rate,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] data,
  input  logic              adv,
  output logic              fire
);
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int FULL_W = CNT_W + 1;
  localparam logic [FULL_W-1:0] ONE  = FULL_W'(1);
  localparam logic [FULL_W-1:0] TWO  = FULL_W'(2);
  localparam logic [FULL_W-1:0] WRAP = ONE << CNT_W;

  logic              rate_q, armed_q, hi_ptr_q;
  logic [BYTE_W-1:0] lo_q;
  logic [FULL_W-1:0] cnt_q, reload_q, eff_div;
  logic [CNT_W-1:0]  raw_div;

  assign raw_div = {data, lo_q};

  always_comb begin
    if (raw_div == '0)
      eff_div = WRAP;
    else if (raw_div == CNT_W'(1))
      eff_div = TWO;
    else
      eff_div = {1'b0, raw_div};
  end

  assign fire = armed_q & rate_q & adv & (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q   <= 1'b0;
      armed_q  <= 1'b0;
      hi_ptr_q <= 1'b0;
      lo_q     <= '0;
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (cfg_wr) begin
      rate_q   <= cfg_rate;
      armed_q  <= 1'b0;
      hi_ptr_q <= 1'b0;
    end else if (data_wr) begin
      if (!hi_ptr_q) begin
        lo_q     <= data;
        hi_ptr_q <= 1'b1;
      end else begin
        reload_q <= eff_div;
        cnt_q    <= eff_div;
        armed_q  <= 1'b1;
        hi_ptr_q <= 1'b0;
      end
    end else if (armed_q && adv) begin
      if (cnt_q == ONE) begin
        if (rate_q) cnt_q <= reload_q;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end
endmodule

// File: rtl/pacer_regs.sv
module pacer_regs #(
  parameter int NSTAGE = 2,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [NSTAGE-1:0] cfg_wr,
  output logic              cfg_rate,
  output logic [NSTAGE-1:0] data_wr,
  output logic              gate_ext_q,
  output logic              aux_int_q
);
  import pacer_pkg::*;
  localparam logic [ADDR_W-1:0] ADDR_EN   = ADDR_W'(NSTAGE);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(NSTAGE + 1);

  logic [SEL_W-1:0] sel;
  assign sel      = wr_data[BYTE_W-1 -: SEL_W];
  assign cfg_rate = (wr_data[3:1] == MODE_RATE);

  for (genvar i = 0; i < NSTAGE; i++) begin : g_dec
    assign cfg_wr[i]  = wr_en && (wr_addr == ADDR_CTRL) && (sel == SEL_W'(i));
    assign data_wr[i] = wr_en && (wr_addr == ADDR_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_ext_q <= 1'b0;
      aux_int_q  <= 1'b0;
    end else if (wr_en && wr_addr == ADDR_EN) begin
      gate_ext_q <= wr_data[0];
      aux_int_q  <= wr_data[1];
    end
  end
endmodule

// File: rtl/pacer_timer.sv
module pacer_timer #(
  parameter int NSTAGE = 2,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tb_ce,
  input  logic              ext_gate,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              tick,
  output logic              aux_clk_int
);
  logic [NSTAGE-1:0] cfg_wr, data_wr, adv, fire;
  logic              cfg_rate, gate_ext_q, aux_int_q, tick_q;

  pacer_regs #(.NSTAGE(NSTAGE), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_wr(cfg_wr), .cfg_rate(cfg_rate), .data_wr(data_wr),
    .gate_ext_q(gate_ext_q), .aux_int_q(aux_int_q)
  );

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign adv[i] = tb_ce & (~gate_ext_q | ext_gate);
    end else begin : g_next
      assign adv[i] = fire[i-1];
    end
    pacer_stage #(.BYTE_W(BYTE_W)) u_stage (
      .clk(clk), .rst(rst), .cfg_wr(cfg_wr[i]), .cfg_rate(cfg_rate),
      .data_wr(data_wr[i]), .data(wr_data), .adv(adv[i]), .fire(fire[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= fire[NSTAGE-1];
  end

  assign tick        = tick_q;
  assign aux_clk_int = aux_int_q;
endmodule

// File: rtl/pacer_timer_chk.sv
module pacer_timer_chk #(
  parameter int NSTAGE = 2,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              tb_ce,
  input logic              ext_gate,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BYTE_W-1:0] wr_data,
  input logic              tick,
  input logic              aux_clk_int,
  input logic              gate_ext_q
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !tick);                                                  // R1
  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);                                                        // R5
  AST_TICK_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(tb_ce));                                                 // R6
  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(!gate_ext_q || ext_gate));                               // R7
  AST_AUX_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(NSTAGE)) |=> (aux_clk_int == $past(wr_data[1]))); // R8
endmodule

bind pacer_timer pacer_timer_chk #(.NSTAGE(NSTAGE), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .tb_ce(tb_ce), .ext_gate(ext_gate), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .tick(tick), .aux_clk_int(aux_clk_int),
  .gate_ext_q(gate_ext_q)
);

// File: tb/sim_pacer_timer.sv
module sim_pacer_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tb_ce = 1'b1;
  logic ext_gate = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic tick, aux_clk_int;

  int n_vec = 0;
  int n_bad = 0;
  int ce_div = 1;
  int ce_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pacer_timer u0 (
    .clk(clk), .rst(rst), .tb_ce(tb_ce), .ext_gate(ext_gate), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .tick(tick), .aux_clk_int(aux_clk_int)
  );

  always @(negedge clk) begin
    if (ce_cnt >= ce_div - 1) begin
      ce_cnt = 0;
      tb_ce  = 1'b1;
    end else begin
      ce_cnt = ce_cnt + 1;
      tb_ce  = 1'b0;
    end
  end

  // Vector table: divisor A, divisor B, tb_ce spacing, expected period in clocks
  localparam int NV = 8;
  localparam int VA[NV]  = '{2, 3, 7, 1, 5, 4, 10, 256};
  localparam int VB[NV]  = '{2, 5, 4, 3, 1, 3, 10, 2};
  localparam int VN[NV]  = '{1, 1, 1, 1, 1, 3, 2, 1};
  localparam int VP[NV]  = '{4, 15, 28, 6, 10, 36, 200, 512};
  localparam string VT[NV] = '{"R2", "R2", "R2", "R4", "R4", "R6", "R6", "R2"};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic program_div(input int da, input int db);
    wr(2'd3, 8'h74); wr(2'd1, db[7:0]); wr(2'd1, db[15:8]);
    wr(2'd3, 8'h34); wr(2'd0, da[7:0]); wr(2'd0, da[15:8]);
  endtask

  task automatic wait_tick(output int c);
    c = 0;
    while (!tick && c < 300000) begin
      @(negedge clk);
      c++;
    end
  endtask

  task automatic measure(output int p, output bit single);
    int c;
    wait_tick(c);
    @(negedge clk);
    single = !tick;
    p = 1;
    while (!tick && p < 300000) begin
      @(negedge clk);
      p++;
    end
  endtask

  task automatic count_ticks(input int n, output int k);
    k = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick) k++;
    end
  endtask

  initial begin
    int p, k, c;
    bit single;
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R1 tick at reset", tick, 0);
    check(aux_clk_int == 1'b0, "R1 aux at reset", aux_clk_int, 0);
    rst = 1'b0;
    count_ticks(100, k);
    check(k == 0, "R1 no tick unprogrammed", k, 0);

    for (int v = 0; v < NV; v++) begin
      ce_div = VN[v];
      program_div(VA[v], VB[v]);
      measure(p, single);
      check(p == VP[v], VT[v], p, VP[v]);
      check(single, "R5 tick width", 0, 1);
    end
    ce_div = 1;

    // R10: low byte alone keeps the period, high byte applies it
    program_div(2, 3);
    measure(p, single);
    check(p == 6, "R10 base period", p, 6);
    wr(2'd0, 8'd9);
    measure(p, single);
    check(p == 6, "R10 low byte only", p, 6);
    wr(2'd0, 8'd0);
    measure(p, single);
    check(p == 27, "R10 after high byte", p, 27);

    // R11: control word for absent stage 2
    wr(2'd3, 8'hB4);
    measure(p, single);
    check(p == 27, "R11 absent stage ignored", p, 27);

    // R9: one-shot mode on stage A stops ticks
    wr(2'd3, 8'h30);
    repeat (3) @(negedge clk);
    count_ticks(200, k);
    check(k == 0, "R9 one-shot stops", k, 0);

    // R7: gated pacing
    wr(2'd2, 8'h01);
    ext_gate = 1'b0;
    program_div(2, 2);
    count_ticks(100, k);
    check(k == 0, "R7 gate low blocks", k, 0);
    ext_gate = 1'b1;
    measure(p, single);
    check(p == 4, "R7 gate high runs", p, 4);
    ext_gate = 1'b0;
    wr(2'd2, 8'h00);
    measure(p, single);
    check(p == 4, "R7 free run ignores gate", p, 4);

    // R8: auxiliary clock select
    wr(2'd2, 8'h02);
    check(aux_clk_int == 1'b1, "R8 aux set", aux_clk_int, 1);
    wr(2'd2, 8'h00);
    check(aux_clk_int == 1'b0, "R8 aux clear", aux_clk_int, 0);

    // R1: reset mid-run returns to silence
    wr(2'd2, 8'h02);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(aux_clk_int == 1'b0, "R1 aux after reset", aux_clk_int, 0);
    count_ticks(100, k);
    check(k == 0, "R1 silent after reset", k, 0);

    // R3: divisor 0 is 65536, first tick latency from the load edge
    program_div(0, 2);
    wait_tick(c);
    check(c == 131072, "R3 divisor zero", c, 131072);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule